// File: doc/BRIEF.md
# Programmable Clock Postscaler

The postscaler turns a stream of input clock enables into a slower periodic waveform. It has two sources of input enables, and a select input picks which one is counted. Every cycle in which the selected enable is high counts as one input tick. A 3-bit ratio code picks the divide factor from an irregular table of factors, both odd and even. The block has two outputs. The first is a divided level whose high phase is as close to half the period as an integer count of ticks allows. The second is a one-cycle pulse that marks the start of each divided period, so downstream logic can use it as a clock enable.

A divider-hold input parks the block. While hold is asserted, both outputs are low and the ratio code has no effect. When hold is released, the block runs one full silent period before the first rising edge. A change of ratio while the block is running never cuts the current period short. The new factor is picked up only when the current period ends, so the output never has a runt pulse.

Top module: `clk_postscaler`

## Requirements
- R1: Ratio codes 0, 1, 2, 3, 4 and 5 give a divided period of 1, 2, 3, 4, 6 and 8 input ticks. There is exactly one `div_rise` pulse per period.
- R2: Ratio codes 6 and 7 both give a divided period of 12 input ticks.
- R3: In each period, `div_clk` is high for ceil(N/2) ticks and low for the rest. For an odd N this is floor(N/2)+1.
- R4: At a factor of 1, `div_clk` copies the selected enable, delayed by one clock cycle.
- R5: After a clock edge at which `div_hold` is 1, or while `rst_n` is 0, `div_clk` and `div_rise` are 0 whatever the ratio code is.
- R6: After `div_hold` falls, the first `div_rise` appears in the cycle after the N-th input tick. N comes from the code present at the first tick.
- R7: The ratio code is sampled only at the first tick after hold, and at the tick that ends a period. A change in the middle of a period leaves that period at its old length.
- R8: `src_sel` = 0 counts `src_en[0]` and `src_sel` = 1 counts `src_en[1]`. The enable that is not selected has no effect.
- R9: `div_rise` is high for one cycle at the start of each high phase. It is high only when `div_clk` is high, and every rising edge of `div_clk` comes with it.
- R10: Outputs only advance on input ticks. A `div_rise` pulse always follows a cycle in which the selected enable was high and hold was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NUM_SRC (2) | Input tick enables, one per source |
| src_sel | input | SEL_W (1) | Index of the source whose enable is counted |
| ratio_code | input | 3 | Divide factor code: 0..7 map to 1, 2, 3, 4, 6, 8, 12, 12 |
| div_hold | input | 1 | Divider hold: forces outputs low and ignores the ratio code |
| div_clk | output | 1 | Divided level output |
| div_rise | output | 1 | One-cycle pulse at the start of each divided period |

## Verification
The assertions assume that `src_en`, `src_sel`, `ratio_code` and `div_hold` are synchronous to `clk` and stable around its rising edge. They also assume that `src_sel` never holds an index beyond the number of sources. The bench changes every input only on the falling clock edge, and it drives `src_sel` with values 0 and 1 only. Random phases mix sparse and dense enables with occasional hold pulses and code changes in the middle of a period. The per-cycle reference model covers these cases, which the directed period measurements do not reach.

// File: rtl/postdiv_pkg.sv
`timescale 1ns/1ps
package postdiv_pkg;

    localparam int CODE_W  = 3;
    localparam int RATIO_W = 4;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;    // ticks already spent in the current period
        ratio_t n;      // divide factor of the current period
        logic   fresh;  // no tick seen since hold or reset
        logic   armed;  // at least one full period completed
        logic   out;    // divided level
        logic   rise;   // period start marker
    } div_state_t;

    // Code to divide factor; codes 6 and 7 share the largest factor.
    function automatic ratio_t code_to_ratio(code_t c);
        ratio_t r;
        case (c)
            3'd0:    r = 4'd1;
            3'd1:    r = 4'd2;
            3'd2:    r = 4'd3;
            3'd3:    r = 4'd4;
            3'd4:    r = 4'd6;
            3'd5:    r = 4'd8;
            default: r = 4'd12;
        endcase
        return r;
    endfunction

    // Number of high ticks per period: ceil(n/2).
    function automatic ratio_t high_span(ratio_t n);
        return (n >> 1) + ratio_t'(n[0]);
    endfunction

endpackage

// File: rtl/postdiv_src_sel.sv
`timescale 1ns/1ps
module postdiv_src_sel #(
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = 1
) (
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_en_i[g] && (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/postdiv_ratio_dec.sv
`timescale 1ns/1ps
module postdiv_ratio_dec
    import postdiv_pkg::*;
(
    input  code_t  code_i,
    output ratio_t ratio_o
);

    assign ratio_o = code_to_ratio(code_i);

endmodule

// File: rtl/postdiv_core.sv
`timescale 1ns/1ps
module postdiv_core
    import postdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   hold_i,
    input  ratio_t ratio_i,
    output logic   div_clk_o,
    output logic   div_rise_o
);

    div_state_t st_q, st_d;
    ratio_t     n_use, pos, pos_nx;
    logic       wrap;

    always_comb begin
        n_use  = st_q.fresh ? ratio_i : st_q.n;
        pos    = st_q.fresh ? '0 : st_q.cnt;
        pos_nx = pos + ratio_t'(1);
        wrap   = (pos == n_use - ratio_t'(1));

        st_d      = st_q;
        st_d.rise = 1'b0;

        if (hold_i) begin
            st_d.cnt   = '0;
            st_d.fresh = 1'b1;
            st_d.armed = 1'b0;
            st_d.out   = 1'b0;
        end else if (tick_i) begin
            st_d.fresh = 1'b0;
            st_d.n     = n_use;
            if (wrap) begin
                st_d.cnt   = '0;
                st_d.n     = ratio_i;
                st_d.armed = 1'b1;
                st_d.out   = 1'b1;
                st_d.rise  = 1'b1;
            end else begin
                st_d.cnt = pos_nx;
                st_d.out = st_q.armed && (pos_nx < high_span(n_use));
            end
        end else if (st_q.n == ratio_t'(1) && !st_q.fresh) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, n: ratio_t'(1), fresh: 1'b1,
                      armed: 1'b0, out: 1'b0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk_o  = st_q.out;
    assign div_rise_o = st_q.rise;

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!div_clk_o && !div_rise_o));

    p_rise_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_rise_o |-> div_clk_o);

    p_edge_marked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk_o) |-> div_rise_o);

    p_rise_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_rise_o |-> $past(tick_i && !hold_i));

    p_count_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.n);

    p_ratio_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.n == 4'd1 || st_q.n == 4'd2 || st_q.n == 4'd3 || st_q.n == 4'd4 ||
         st_q.n == 4'd6 || st_q.n == 4'd8 || st_q.n == 4'd12));

    p_ratio_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.n) |-> (div_rise_o || $past(st_q.fresh)));

endmodule

// File: rtl/clk_postscaler.sv
`timescale 1ns/1ps
module clk_postscaler
    import postdiv_pkg::*;
#(
    parameter int NUM_SRC = 2,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [CODE_W-1:0]  ratio_code,
    input  logic               div_hold,
    output logic               div_clk,
    output logic               div_rise
);

    logic   tick;
    ratio_t ratio;

    postdiv_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .src_en_i (src_en),
        .sel_i    (src_sel),
        .tick_o   (tick)
    );

    postdiv_ratio_dec u_dec (
        .code_i  (ratio_code),
        .ratio_o (ratio)
    );

    postdiv_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .hold_i     (div_hold),
        .ratio_i    (ratio),
        .div_clk_o  (div_clk),
        .div_rise_o (div_rise)
    );

    p_sel_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_rise && !$past(div_hold)) |-> $past(src_en[src_sel]) || !$stable(src_sel));

endmodule

// File: tb/tb_clk_postscaler.sv
`timescale 1ns/1ps
module tb_clk_postscaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_en = 2'b00;
    logic [0:0] src_sel = 1'b0;
    logic [2:0] ratio_code = 3'd0;
    logic       div_hold = 1'b1;
    logic       div_clk, div_rise;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    int mode = 0;       // 0: static enables, 1: en[1] every third cycle, 2: random
    int cyc = 0;
    bit rand_ctl = 0;
    bit en0_last = 0;

    always #4 clk = ~clk;

    clk_postscaler dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_sel(src_sel),
        .ratio_code(ratio_code), .div_hold(div_hold),
        .div_clk(div_clk), .div_rise(div_rise)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int factor(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 3;
            3: return 4;  4: return 6;  5: return 8;
            default: return 12;
        endcase
    endfunction

    // Behavioural reference: ticks counted within a period of N.
    int m_pos = 0, m_n = 1;
    bit m_start = 1, m_live = 0, m_out = 0, m_rise = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos = 0; m_n = 1; m_start = 1; m_live = 0; m_out = 0; m_rise = 0;
        end else begin
            bit t;
            t = src_en[src_sel];
            m_rise = 0;
            if (div_hold) begin
                m_pos = 0; m_start = 1; m_live = 0; m_out = 0;
            end else if (t) begin
                int len, p;
                len = m_start ? factor(ratio_code) : m_n;
                p = m_start ? 0 : m_pos;
                m_n = len;
                m_start = 0;
                if (p == len - 1) begin
                    m_pos = 0; m_n = factor(ratio_code);
                    m_live = 1; m_out = 1; m_rise = 1;
                end else begin
                    m_pos = p + 1;
                    m_out = m_live && (p + 1 < (len + 1) / 2);
                end
            end else if (m_n == 1 && !m_start) begin
                m_out = 0;
            end
        end
    end

    always @(posedge clk) en0_last <= src_en[0];

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(div_clk == m_out, cur_req, div_clk, m_out);
            check(div_rise == m_rise, cur_req, div_rise, m_rise);
        end
    end

    // Input driver on the falling edge.
    always @(negedge clk) begin
        cyc++;
        case (mode)
            0: ;
            1: src_en <= {(cyc % 3 == 0), 1'b1};
            default: src_en <= 2'($urandom);
        endcase
        if (rand_ctl) begin
            if ($urandom_range(99) < 3) ratio_code <= 3'($urandom);
            if ($urandom_range(99) < 3) src_sel <= 1'($urandom);
            div_hold <= ($urandom_range(99) < 2);
        end
    end

    task automatic restart(input int code);
        @(negedge clk);
        div_hold = 1'b1;
        ratio_code = 3'(code);
        repeat (2) @(negedge clk);
        div_hold = 1'b0;
    endtask

    task automatic gap_to_rise(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!div_rise && g < 100);
    endtask

    initial begin
        int g;
        // Reset state
        repeat (3) @(negedge clk);
        check(div_clk == 0 && div_rise == 0, "R5", {div_clk, div_rise}, 0);
        rst_n = 1'b1;

        // R1, R2, R3: period and high time for every code, enable every cycle
        mode = 0;
        src_en = 2'b01;
        src_sel = 1'b0;
        for (int c = 0; c < 8; c++) begin
            int rises, highs, n;
            cur_req = (c >= 6) ? "R2" : "R1";
            restart(c);
            repeat (30) @(negedge clk);
            rises = 0; highs = 0;
            n = factor(c);
            for (int k = 0; k < 48; k++) begin
                @(negedge clk);
                rises += div_rise;
                highs += div_clk;
            end
            check(rises == 48 / n, (c >= 6) ? "R2" : "R1", rises, 48 / n);
            check(highs == 48 * ((n + 1) / 2) / n, "R3", highs, 48 * ((n + 1) / 2) / n);
        end

        // R6: first rise one full period after release
        cur_req = "R6";
        restart(3);
        gap_to_rise(g);
        check(g == 4, "R6", g, 4);
        restart(2);
        gap_to_rise(g);
        check(g == 3, "R6", g, 3);

        // R7: change in mid-period takes effect at the boundary
        cur_req = "R7";
        restart(5);
        gap_to_rise(g);
        ratio_code = 3'd0;
        gap_to_rise(g);
        check(g == 8, "R7", g, 8);
        gap_to_rise(g);
        check(g == 1, "R7", g, 1);

        // R8: selected source is counted, other ignored
        cur_req = "R8";
        mode = 1;
        src_sel = 1'b1;
        restart(1);
        gap_to_rise(g);
        gap_to_rise(g);
        check(g == 6, "R8", g, 6);
        gap_to_rise(g);
        check(g == 6, "R8", g, 6);

        // R4: divide-by-1 follows the selected enable one cycle later
        cur_req = "R4";
        mode = 2;
        src_sel = 1'b0;
        restart(0);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check(div_clk == en0_last, "R4", div_clk, en0_last);
        end

        // R5: hold keeps outputs low while code and enables toggle
        cur_req = "R5";
        div_hold = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            ratio_code = 3'(k);
            @(negedge clk);
            check(div_clk == 0 && div_rise == 0, "R5", {div_clk, div_rise}, 0);
        end
        div_hold = 1'b0;

        // R9, R10: random traffic compared cycle by cycle
        cur_req = "R9";
        rand_ctl = 1;
        repeat (1500) @(negedge clk);
        cur_req = "R10";
        repeat (1500) @(negedge clk);
        rand_ctl = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule